// File: doc/BRIEF.md
# Accumulator CPU Fetch/Execute Sequencer

This block is a hardwired finite-state sequencer for a small 8-bit accumulator processor whose program and data share one 16-byte memory. Every instruction starts with a two-state fetch. In the first fetch state the program counter is copied into the address register. In the second fetch state the addressed word is captured as the instruction, the program counter advances, and the next state is chosen from the fetched opcode. One to two execute states follow, and then control returns to the first fetch state. A halt state absorbs every later cycle.

The program counter is clocked on the falling edge. The increment requested during the decode state therefore completes within that same cycle. The state register, address register, instruction register, accumulator, output register, flags and memory all update on the rising edge. The memory image is a parameter, so a program is set up at elaboration and no load port is needed. The accumulator path, the ALU and the memory sit inside the block so that programs can be checked end to end at the output register.

Instruction format: bits 7:4 hold the opcode and bits 3:0 hold a memory address or an immediate value.

Top module: `acc_seq_cpu`

## Requirements
- R1: A synchronous active-high `rst` does the following. It clears the state to the first fetch state. It clears the accumulator, output register, instruction register and both flags on the rising edge. It clears the program counter on the falling edge. Memory contents are not touched.
- R2: The first fetch state (FETCH_ADDR) always goes to the decode state (FETCH_DECODE) and loads the address register from the program counter. The program counter keeps its value through the rising edge that ends FETCH_ADDR.
- R3: During FETCH_DECODE the instruction register loads the addressed word on the rising edge. The program counter becomes PC+1 (mod 16) at the falling edge in the middle of that cycle.
- R4: For opcode 0x1 (load), 0x2 (add) and 0x3 (subtract), state OPND_ADDR puts the low nibble in the address register. The second state then does one of two things. MEM_TO_A copies memory into the accumulator. MEM_ALU writes the accumulator plus or minus the memory word back into the accumulator.
- R5: Carry and zero are written only in MEM_ALU. For add, carry is bit 8 of the 9-bit sum. For subtract, carry is bit 8 of A + ~M + 1, so 1 means no borrow. Zero is set when the 8-bit result is 0.
- R6: Opcode 0x5 goes through state IMM_TO_A, which loads the accumulator with the low nibble zero-extended.
- R7: Opcode 0x6 goes through state BRANCH, which loads the program counter with the low nibble on the falling edge.
- R8: Opcode 0x7 (jump if carry) and 0x8 (jump if zero) go from FETCH_DECODE to BRANCH when their flag is 1. Otherwise they go straight back to FETCH_ADDR and take 2 cycles.
- R9: Opcode 0xE goes through state A_TO_OUT. That state raises `out_strobe_o` for one cycle, and the output register takes the accumulator at the end of the cycle.
- R10: Opcode 0xF enters HALT. HALT loops to itself, asserts no datapath strobe, and leaves the program counter and output register unchanged.
- R11: Opcode 0x0 and the undefined opcodes 0x9–0xD act as no-operation: FETCH_DECODE goes straight to FETCH_ADDR, for 2 cycles in total.
- R12: Instruction costs in cycles are: load, add, subtract and store 4; immediate load, jump, taken branch and output 3; not-taken branch and no-op 2. The halt instruction enters HALT 2 cycles after it starts.
- R13: Opcode 0x4 goes through OPND_ADDR and then A_TO_MEM, which writes the accumulator into the shared memory at the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC on falling edge, everything else on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | ADDR_W | Program counter |
| out_o | output | DATA_W | Output register |
| out_strobe_o | output | 1 | High during the output-load state |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| halted_o | output | 1 | High while in HALT |

## Verification
The decode cycle combines three actions: capturing the instruction, advancing the program counter on the falling edge, and choosing the next state from the memory word, which for conditional branches also depends on the flags. A branch adds a fourth action, a falling-edge load of the program counter, so the increment and the jump target must never collide. Two programs exercise this. One places taken and not-taken branches right after the add and subtract that set the flags, and one places a jump over an output instruction. The bench samples the program counter half a cycle into the first decode cycle, then judges the whole sequence from the output values written, the exact cycle in which HALT is entered and the final program counter.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP = 4'h0;
    localparam logic [OP_W-1:0] OP_LDA = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD = 4'h2;
    localparam logic [OP_W-1:0] OP_SUB = 4'h3;
    localparam logic [OP_W-1:0] OP_STA = 4'h4;
    localparam logic [OP_W-1:0] OP_LDI = 4'h5;
    localparam logic [OP_W-1:0] OP_JMP = 4'h6;
    localparam logic [OP_W-1:0] OP_JC  = 4'h7;
    localparam logic [OP_W-1:0] OP_JZ  = 4'h8;
    localparam logic [OP_W-1:0] OP_OUT = 4'hE;
    localparam logic [OP_W-1:0] OP_HLT = 4'hF;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_DECODE,
        ST_OPND_ADDR,
        ST_MEM_TO_A,
        ST_MEM_ALU,
        ST_A_TO_MEM,
        ST_IMM_TO_A,
        ST_BRANCH,
        ST_A_TO_OUT,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic ir_load;
        logic pc_inc;
        logic pc_load;
        logic a_from_mem;
        logic a_from_alu;
        logic a_from_imm;
        logic mem_write;
        logic out_load;
        logic alu_sub;
        logic flags_load;
    } ctrl_t;

endpackage

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] mem_op,
    input  logic [OP_W-1:0] ir_op,
    input  logic            carry,
    input  logic            zero,
    output state_e          state_o,
    output ctrl_t           ctrl_o
);

    state_e state_q;
    state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_ADDR:   state_d = ST_FETCH_DECODE;
            ST_FETCH_DECODE: begin
                case (mem_op)
                    OP_LDA, OP_ADD,
                    OP_SUB, OP_STA: state_d = ST_OPND_ADDR;
                    OP_LDI:         state_d = ST_IMM_TO_A;
                    OP_JMP:         state_d = ST_BRANCH;
                    OP_JC:          state_d = carry ? ST_BRANCH : ST_FETCH_ADDR;
                    OP_JZ:          state_d = zero  ? ST_BRANCH : ST_FETCH_ADDR;
                    OP_OUT:         state_d = ST_A_TO_OUT;
                    OP_HLT:         state_d = ST_HALT;
                    default:        state_d = ST_FETCH_ADDR;
                endcase
            end
            ST_OPND_ADDR: begin
                case (ir_op)
                    OP_LDA:         state_d = ST_MEM_TO_A;
                    OP_ADD, OP_SUB: state_d = ST_MEM_ALU;
                    default:        state_d = ST_A_TO_MEM;
                endcase
            end
            ST_MEM_TO_A,
            ST_MEM_ALU,
            ST_A_TO_MEM,
            ST_IMM_TO_A,
            ST_BRANCH,
            ST_A_TO_OUT:     state_d = ST_FETCH_ADDR;
            ST_HALT:         state_d = ST_HALT;
            default:         state_d = ST_FETCH_ADDR;
        endcase
    end

    // Output decode
    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            ST_FETCH_ADDR:   ctrl_o.mar_from_pc = 1'b1;
            ST_FETCH_DECODE: begin
                ctrl_o.ir_load = 1'b1;
                ctrl_o.pc_inc  = 1'b1;
            end
            ST_OPND_ADDR:    ctrl_o.mar_from_ir = 1'b1;
            ST_MEM_TO_A:     ctrl_o.a_from_mem  = 1'b1;
            ST_MEM_ALU: begin
                ctrl_o.a_from_alu = 1'b1;
                ctrl_o.flags_load = 1'b1;
                ctrl_o.alu_sub    = (ir_op == OP_SUB);
            end
            ST_A_TO_MEM:     ctrl_o.mem_write  = 1'b1;
            ST_IMM_TO_A:     ctrl_o.a_from_imm = 1'b1;
            ST_BRANCH:       ctrl_o.pc_load    = 1'b1;
            ST_A_TO_OUT:     ctrl_o.out_load   = 1'b1;
            ST_HALT:         ctrl_o = '0;
            default:         ctrl_o = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/acc_seq_pc.sv
module acc_seq_pc #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    // Falling-edge update so the decode-state increment lands inside that cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (load) begin
            pc <= target;
        end else if (inc) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/acc_seq_ram.sv
module acc_seq_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i] = INIT_IMAGE[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] result,
    output logic         carry,
    output logic         zero
);

    logic [W:0]   sum;
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff  = sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        result = sum[W-1:0];
        carry  = sum[W];
        zero   = (sum[W-1:0] == '0);
    end

endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DATA_W = OP_W + ADDR_W,
    localparam int DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] out_o,
    output logic              out_strobe_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              halted_o
);

    state_e            state;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] out_q;
    logic              carry_q;
    logic              zero_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              alu_zero;
    logic [OP_W-1:0]   mem_op;
    logic [OP_W-1:0]   ir_op;
    logic [ADDR_W-1:0] operand;

    assign mem_op  = mem_rdata[DATA_W-1 -: OP_W];
    assign ir_op   = ir_q[DATA_W-1 -: OP_W];
    assign operand = ir_q[ADDR_W-1:0];

    acc_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .mem_op  (mem_op),
        .ir_op   (ir_op),
        .carry   (carry_q),
        .zero    (zero_q),
        .state_o (state),
        .ctrl_o  (ctrl)
    );

    acc_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .inc    (ctrl.pc_inc),
        .load   (ctrl.pc_load),
        .target (operand),
        .pc     (pc_q)
    );

    acc_seq_ram #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_ram (
        .clk   (clk),
        .we    (ctrl.mem_write),
        .addr  (mar_q),
        .wdata (acc_q),
        .rdata (mem_rdata)
    );

    acc_seq_alu #(.W(DATA_W)) u_alu (
        .a      (acc_q),
        .b      (mem_rdata),
        .sub    (ctrl.alu_sub),
        .result (alu_res),
        .carry  (alu_carry),
        .zero   (alu_zero)
    );

    // Rising-edge datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q   <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            out_q   <= '0;
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            if (ctrl.mar_from_pc) mar_q <= pc_q;
            if (ctrl.mar_from_ir) mar_q <= operand;
            if (ctrl.ir_load)     ir_q  <= mem_rdata;
            if (ctrl.a_from_mem)  acc_q <= mem_rdata;
            if (ctrl.a_from_alu)  acc_q <= alu_res;
            if (ctrl.a_from_imm)  acc_q <= {{(DATA_W-ADDR_W){1'b0}}, operand};
            if (ctrl.out_load)    out_q <= acc_q;
            if (ctrl.flags_load) begin
                carry_q <= alu_carry;
                zero_q  <= alu_zero;
            end
        end
    end

    assign pc_o         = pc_q;
    assign out_o        = out_q;
    assign out_strobe_o = ctrl.out_load;
    assign carry_o      = carry_q;
    assign zero_o       = zero_q;
    assign halted_o     = (state == ST_HALT);

endmodule

// File: rtl/acc_seq_cpu_chk.sv
module acc_seq_cpu_chk
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic              carry,
    input logic              zero,
    input logic [DATA_W-1:0] out_val,
    input logic              halted
);

    assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_ADDR) |=> (state == ST_FETCH_DECODE));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_DECODE) |-> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_MEM_ALU) |=> $stable({carry, zero}));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> ($stable(pc) && $stable(out_val)));

endmodule

bind acc_seq_cpu acc_seq_cpu_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .pc      (pc_q),
    .carry   (carry_q),
    .zero    (zero_q),
    .out_val (out_q),
    .halted  (halted_o)
);

// File: tb/test_acc_seq_cpu.sv
module test_acc_seq_cpu;

    // Program A: load, add, output, subtract to zero, taken branch on carry,
    // store, reload, output, taken branch on zero to a halt at address 5.
    localparam logic [127:0] PROG_A =
        128'h07_05_0C_55_00_00_85_E0_1C_4C_F0_76_3D_E0_2F_1E;
    // Program B: immediate load, add with carry out, not-taken JZ, undefined
    // opcode, output, jump over an output, borrowing subtract, not-taken JC.
    localparam logic [127:0] PROG_B =
        128'h05_F3_00_00_F0_E0_76_3F_F0_E0_68_E0_A0_89_2E_5F;

    // {instance select (0=A,1=B), expected output value}, in output order
    localparam logic [8:0] EXP_OUTS [4] = '{9'h00C, 9'h000, 9'h102, 9'h1FD};

    logic clk = 1'b0;
    logic rst_a = 1'b1;
    logic rst_b = 1'b1;

    logic [3:0] pc_a, pc_b;
    logic [7:0] out_a, out_b;
    logic       stb_a, stb_b, c_a, c_b, z_a, z_b, h_a, h_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_seq_cpu #(.ADDR_W(4), .INIT_IMAGE(PROG_A)) i_acc_seq_cpu (
        .clk(clk), .rst(rst_a), .pc_o(pc_a), .out_o(out_a), .out_strobe_o(stb_a),
        .carry_o(c_a), .zero_o(z_a), .halted_o(h_a)
    );

    acc_seq_cpu #(.ADDR_W(4), .INIT_IMAGE(PROG_B)) i_acc_seq_cpu_b (
        .clk(clk), .rst(rst_b), .pc_o(pc_b), .out_o(out_b), .out_strobe_o(stb_b),
        .carry_o(c_b), .zero_o(z_b), .halted_o(h_b)
    );

    // Monitor: cycle counts since reset release and logged output values
    int         cnt_a = 0, cnt_b = 0, halt_at_a = 0, halt_at_b = 0;
    logic       done_a = 1'b0, done_b = 1'b0;
    logic       prev_stb_a = 1'b0, prev_stb_b = 1'b0;
    logic [7:0] log_a [4];
    logic [7:0] log_b [4];
    int         n_a = 0, n_b = 0;

    always @(negedge clk) begin
        if (rst_a) begin
            cnt_a = 0; done_a = 1'b0; prev_stb_a = 1'b0;
        end else begin
            cnt_a++;
            if (h_a && !done_a) begin done_a = 1'b1; halt_at_a = cnt_a; end
            if (prev_stb_a && n_a < 4) begin log_a[n_a] = out_a; n_a++; end
            prev_stb_a = stb_a;
        end
        if (rst_b) begin
            cnt_b = 0; done_b = 1'b0; prev_stb_b = 1'b0;
        end else begin
            cnt_b++;
            if (h_b && !done_b) begin done_b = 1'b1; halt_at_b = cnt_b; end
            if (prev_stb_b && n_b < 4) begin log_b[n_b] = out_b; n_b++; end
            prev_stb_b = stb_b;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected halt");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] pc_hold;
        int ka;
        int kb;
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        // R1: state while held in reset
        check("R1 reset pc", 32'(pc_a), 32'h0);
        check("R1 reset out", 32'(out_a), 32'h0);
        check("R1 reset flags", 32'({c_a, z_a}), 32'h0);
        check("R1 reset halted", 32'(h_a), 32'h0);
        rst_a = 1'b0;
        rst_b = 1'b0;
        @(posedge clk); #2;
        check("R2 pc held after FETCH_ADDR", 32'(pc_a), 32'h0);
        @(negedge clk); #2;
        check("R3 pc advanced mid decode", 32'(pc_a), 32'h1);

        wait (done_a && done_b);
        repeat (4) @(posedge clk);
        #2;
        check("R12 halt cycle program A", 32'(halt_at_a), 32'd34);
        check("R12 R11 halt cycle program B", 32'(halt_at_b), 32'd28);
        check("R8 R10 final pc program A", 32'(pc_a), 32'h6);
        check("R7 R8 final pc program B", 32'(pc_b), 32'hC);
        check("R7 output count A", 32'(n_a), 32'd2);
        check("R7 output count B (jumped-over OUT)", 32'(n_b), 32'd2);
        check("R5 flags A after zero subtract", 32'({c_a, z_a}), 32'h2 | 32'h1);
        check("R5 flags B after borrow", 32'({c_b, z_b}), 32'h0);

        // Vector walk: R4 R6 R9 R11 R13 output sequence
        ka = 0;
        kb = 0;
        for (int i = 0; i < 4; i++) begin
            if (EXP_OUTS[i][8] == 1'b0) begin
                check("R4 R9 R13 output vector A", 32'(log_a[ka]), 32'(EXP_OUTS[i][7:0]));
                ka++;
            end else begin
                check("R6 R9 R11 output vector B", 32'(log_b[kb]), 32'(EXP_OUTS[i][7:0]));
                kb++;
            end
        end

        // R10: halt holds
        pc_hold = pc_a;
        repeat (5) @(posedge clk);
        #2;
        check("R10 halted stays", 32'(h_a), 32'h1);
        check("R10 pc frozen", 32'(pc_a), 32'(pc_hold));
        check("R10 out frozen", 32'(out_a), 32'h0);

        // R1: reset after halt, then rerun
        @(negedge clk); #2;
        rst_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); #2;
        check("R1 re-reset pc", 32'(pc_a), 32'h0);
        check("R1 re-reset halted", 32'(h_a), 32'h0);
        check("R1 re-reset flags", 32'({c_a, z_a}), 32'h0);
        check("R1 re-reset out", 32'(out_a), 32'h0);
        rst_a = 1'b0;
        wait (done_a);
        @(posedge clk); #2;
        check("R12 halt cycle rerun", 32'(halt_at_a), 32'd34);
        check("R1 rerun final pc", 32'(pc_a), 32'h6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule